// File: doc/BRIEF.md
# Service Request Acknowledge Vectoring

This block is the acknowledge front end of a multi-channel serial controller. The host programs a device identifier and three service levels through a small register port. Later, the host runs an acknowledge cycle by raising a strobe with a level on the address bus. The block compares that level with the three programmed levels and checks which request types are pending. If it finds a match, it enables its output and drives a vector. The vector is the 5-bit identifier followed by a 3-bit group code that tells the host which service routine to run. In a cascade, each device gets a distinct identifier, so the answering device can be told apart from the others.

A matched acknowledge opens a service context. The context latches the request type and the active channel number, and it stays open until the host pulses an end-of-service strobe. There are three general channel registers, one for each request type, and they keep whatever the host writes in them. When one of them is read, bits 4:2 of the returned value are replaced by a channel number. During a context that number is the serviced channel. Outside a context it is the current channel-access value. The remaining bits work as a saved per-type sub-vector.

Top module: `svc_ack_vector`

## Requirements
- R1: After reset, every register reads as zero apart from the overlay field, no context is open, and vec_oe is low.
- R2: Select 0 addresses the vector register. A write stores only wr_data[7:3]. A read returns the stored 5 bits in [7:3] and, in [2:0], the group code of the open context (000 when no context is open).
- R3: Selects 1, 2 and 3 are the modem, transmit and receive level registers. Each stores and reads back all 8 bits.
- R4: While ack_strobe is high and no context is open, vec_oe is high in the same cycle when ack_addr equals the level of a pending type. vec_out is then {identifier, code}, with codes 001 for modem, 010 for transmit and 011 for receive. The pending bits are pend[0] modem, pend[1] transmit and pend[2] receive.
- R5: When more than one pending type matches, receive wins over transmit, and transmit wins over modem.
- R6: With no match, no pending match, or no strobe, vec_oe stays low and no context opens.
- R7: On the clock edge of an answered acknowledge, a context opens and latches act_chan and the code. While the context is open, further acknowledges get no answer and leave the latched values unchanged.
- R8: An end_svc pulse closes an open context at the next edge.
- R9: Selects 4, 5 and 6 are the modem, transmit and receive channel registers. A read returns the stored byte with bits 4:2 replaced by the serviced channel when a context is open, or by car_val when none is open. All other bits come from storage, and the stored byte itself is never altered by the overlay.
- R10: Select 7 reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for reg_sel, combinational |
| ack_strobe | input | 1 | Acknowledge cycle in progress |
| ack_addr | input | 8 | Service level presented during acknowledge |
| pend | input | 3 | Pending flags {receive, transmit, modem} |
| act_chan | input | 3 | Channel currently requesting service |
| car_val | input | 3 | Current channel-access value |
| end_svc | input | 1 | End-of-service strobe |
| vec_out | output | 8 | Acknowledge vector {identifier, code} |
| vec_oe | output | 1 | Drive enable for vec_out |

## Verification
The first sweep gives the three levels distinct values and crosses all eight pending patterns with each level and with one unmatched address. This separates a correct match from a wrong type, a missing pending qualification and a false answer. The second sweep gives all three levels the same value, so every pending pattern exposes the priority order directly. Each answered acknowledge is followed by register reads that confirm the latched code and channel. A repeat acknowledge inside the context is checked to get no answer. The channel registers are also read across every car_val value with a mixed stored byte, which separates the overlay field from the stored bits.

// File: rtl/svc_ack_pkg.sv
package svc_ack_pkg;
   localparam int SEL_W       = 3;
   localparam int NUM_TYPES   = 3;
   localparam int SEL_VECTOR  = 0;
   localparam int SEL_LVL_BASE = 1;
   localparam int SEL_GCR_BASE = SEL_LVL_BASE + NUM_TYPES;

   typedef enum logic [1:0] {
      TY_MODEM = 2'd0,
      TY_TX    = 2'd1,
      TY_RX    = 2'd2
   } svc_type_e;

   function automatic logic [2:0] grp_code_of(input int idx);
      return 3'(idx + 1);
   endfunction
endpackage

// File: rtl/svc_regfile.sv
module svc_regfile
   import svc_ack_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int UID_W  = 5,
   parameter int NTYPES = NUM_TYPES
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [SEL_W-1:0]               wr_sel,
   input  logic [DATA_W-1:0]              wr_data,
   output logic [UID_W-1:0]               uid,
   output logic [NTYPES-1:0][DATA_W-1:0]  lvl,
   output logic [NTYPES-1:0][DATA_W-1:0]  gcr
);
   localparam int GCR_BASE = SEL_LVL_BASE + NTYPES;

   if (GCR_BASE + NTYPES > (1 << SEL_W)) begin : g_bad_sel
      $error("register select too narrow for type count");
   end
   if (UID_W >= DATA_W) begin : g_bad_uid
      $error("identifier must leave room for the group code");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         uid <= '0;
      end else if (wr_en && wr_sel == SEL_W'(SEL_VECTOR)) begin
         uid <= wr_data[DATA_W-1 -: UID_W];
      end
   end

   for (genvar t = 0; t < NTYPES; t++) begin : g_type
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lvl[t] <= '0;
            gcr[t] <= '0;
         end else if (wr_en) begin
            if (wr_sel == SEL_W'(SEL_LVL_BASE + t)) lvl[t] <= wr_data;
            if (wr_sel == SEL_W'(GCR_BASE + t))     gcr[t] <= wr_data;
         end
      end
   end

   p_uid_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == SEL_W'(SEL_VECTOR)) |=> $stable(uid));
   p_none_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == {SEL_W{1'b1}}) |=> ($stable(lvl) && $stable(gcr) && $stable(uid)));
endmodule

// File: rtl/svc_match.sv
module svc_match
   import svc_ack_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8,
   parameter int GRP_W  = 3,
   parameter int NTYPES = NUM_TYPES
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           ack_strobe,
   input  logic                           allow,
   input  logic [ADDR_W-1:0]              ack_addr,
   input  logic [NTYPES-1:0][DATA_W-1:0]  lvl,
   input  logic [NTYPES-1:0]              pend,
   output logic                           any_hit,
   output logic [GRP_W-1:0]               code
);
   if (ADDR_W > DATA_W) begin : g_bad_addr
      $error("address wider than level registers");
   end
   if (NTYPES + 1 > (1 << GRP_W)) begin : g_bad_grp
      $error("group code too narrow");
   end

   logic [NTYPES-1:0] hit;
   logic [NTYPES-1:0] grant;

   for (genvar t = 0; t < NTYPES; t++) begin : g_cmp
      assign hit[t] = ack_strobe && allow && pend[t] &&
                      (ack_addr == lvl[t][ADDR_W-1:0]);
   end

   // highest type index wins: receive over transmit over modem
   always_comb begin
      grant = '0;
      code  = '0;
      for (int t = 0; t < NTYPES; t++) begin
         if (hit[t]) begin
            grant = '0;
            grant[t] = 1'b1;
            code = GRP_W'(t + 1);
         end
      end
   end

   assign any_hit = |hit;

   p_grant_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   p_code_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      any_hit |-> (code != '0));
   p_rx_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit[NTYPES-1] |-> (code == GRP_W'(NTYPES)));
endmodule

// File: rtl/svc_context.sv
module svc_context #(
   parameter int CHAN_W = 3,
   parameter int GRP_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [GRP_W-1:0]  take_code,
   input  logic [CHAN_W-1:0] act_chan,
   input  logic              end_svc,
   output logic              ctx_active,
   output logic [CHAN_W-1:0] ctx_chan,
   output logic [GRP_W-1:0]  ctx_code
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctx_active <= 1'b0;
         ctx_chan   <= '0;
         ctx_code   <= '0;
      end else if (take) begin
         ctx_active <= 1'b1;
         ctx_chan   <= act_chan;
         ctx_code   <= take_code;
      end else if (end_svc) begin
         ctx_active <= 1'b0;
         ctx_code   <= '0;
      end
   end

   p_take_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (ctx_active && ctx_code == $past(take_code) && ctx_chan == $past(act_chan)));
   p_ctx_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_active && !end_svc) |=> (ctx_active && $stable(ctx_chan) && $stable(ctx_code)));
   p_end_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_active && end_svc) |=> !ctx_active);
   p_take_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> !ctx_active);
endmodule

// File: rtl/svc_ack_vector.sv
module svc_ack_vector
   import svc_ack_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 8,
   parameter int UID_W   = 5,
   parameter int CHAN_W  = 3,
   parameter int OVL_LSB = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              ack_strobe,
   input  logic [ADDR_W-1:0] ack_addr,
   input  logic [2:0]        pend,
   input  logic [CHAN_W-1:0] act_chan,
   input  logic [CHAN_W-1:0] car_val,
   input  logic              end_svc,
   output logic [DATA_W-1:0] vec_out,
   output logic              vec_oe
);
   localparam int GRP_W   = DATA_W - UID_W;
   localparam int NTYPES  = NUM_TYPES;
   localparam int OVL_MSB = OVL_LSB + CHAN_W - 1;

   if (OVL_MSB >= DATA_W) begin : g_bad_ovl
      $error("overlay field exceeds register width");
   end

   logic [UID_W-1:0]              uid;
   logic [NTYPES-1:0][DATA_W-1:0] lvl;
   logic [NTYPES-1:0][DATA_W-1:0] gcr;
   logic                          any_hit;
   logic [GRP_W-1:0]              code;
   logic                          ctx_active;
   logic [CHAN_W-1:0]             ctx_chan;
   logic [GRP_W-1:0]              ctx_code;
   logic [CHAN_W-1:0]             ovl_chan;

   svc_regfile #(.DATA_W(DATA_W), .UID_W(UID_W), .NTYPES(NTYPES)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(reg_sel),
      .wr_data(wr_data), .uid(uid), .lvl(lvl), .gcr(gcr)
   );

   svc_match #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .GRP_W(GRP_W), .NTYPES(NTYPES)) u_match (
      .clk(clk), .rst_n(rst_n), .ack_strobe(ack_strobe), .allow(!ctx_active),
      .ack_addr(ack_addr), .lvl(lvl), .pend(pend), .any_hit(any_hit), .code(code)
   );

   svc_context #(.CHAN_W(CHAN_W), .GRP_W(GRP_W)) u_ctx (
      .clk(clk), .rst_n(rst_n), .take(any_hit), .take_code(code),
      .act_chan(act_chan), .end_svc(end_svc), .ctx_active(ctx_active),
      .ctx_chan(ctx_chan), .ctx_code(ctx_code)
   );

   assign vec_oe   = any_hit;
   assign vec_out  = {uid, code};
   assign ovl_chan = ctx_active ? ctx_chan : car_val;

   always_comb begin
      rd_data = '0;
      if (reg_sel == SEL_W'(SEL_VECTOR)) begin
         rd_data = {uid, ctx_code};
      end
      for (int t = 0; t < NTYPES; t++) begin
         if (reg_sel == SEL_W'(SEL_LVL_BASE + t)) begin
            rd_data = lvl[t];
         end
         if (reg_sel == SEL_W'(SEL_GCR_BASE + t)) begin
            rd_data = gcr[t];
            rd_data[OVL_MSB:OVL_LSB] = ovl_chan;
         end
      end
   end

   p_oe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vec_oe |-> (ack_strobe && !ctx_active));
   p_no_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!vec_oe && !ctx_active) |=> !ctx_active);
   p_vec_uid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      vec_oe |-> (vec_out[DATA_W-1 -: UID_W] == rd_data[DATA_W-1 -: UID_W] ||
                  reg_sel != SEL_W'(SEL_VECTOR)));
endmodule

// File: tb/sim_svc_ack_vector.sv
module sim_svc_ack_vector;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] reg_sel = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       ack_strobe = 1'b0;
   logic [7:0] ack_addr = '0;
   logic [2:0] pend = '0;
   logic [2:0] act_chan = '0;
   logic [2:0] car_val = '0;
   logic       end_svc = 1'b0;
   logic [7:0] vec_out;
   logic       vec_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   localparam logic [4:0] UID = 5'b10110;

   always #4 clk = ~clk;

   svc_ack_vector u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
      .wr_data(wr_data), .rd_data(rd_data), .ack_strobe(ack_strobe),
      .ack_addr(ack_addr), .pend(pend), .act_chan(act_chan),
      .car_val(car_val), .end_svc(end_svc), .vec_out(vec_out), .vec_oe(vec_oe)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; reg_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] sel, output logic [7:0] d);
      reg_sel = sel;
      #1;
      d = rd_data;
   endtask

   task automatic close_ctx();
      @(negedge clk);
      end_svc = 1'b1;
      @(negedge clk);
      end_svc = 1'b0;
   endtask

   function automatic logic [7:0] ovl(input logic [7:0] s, input logic [2:0] c);
      return (s & ~8'h1C) | {3'b000, c, 2'b00};
   endfunction

   // one acknowledge: drives at a falling edge, checks before and after the rising edge
   task automatic ack_case(input logic [2:0] pd, input logic [7:0] addr,
                           input logic [2:0] exp_code, input logic [2:0] ch,
                           input logic [7:0] gsave, input string tag);
      logic [7:0] d;
      @(negedge clk);
      pend = pd; ack_addr = addr; act_chan = ch; ack_strobe = 1'b1;
      #1;
      chk({tag, " vec_oe"}, {7'd0, vec_oe}, {7'd0, exp_code != 3'd0});
      if (exp_code != 3'd0) chk({tag, " vec_out"}, vec_out, {UID, exp_code});
      @(negedge clk);
      ack_strobe = 1'b0;
      rd(3'd0, d);
      chk("R2 R7 latched code", d, {UID, exp_code});
      if (exp_code != 3'd0) begin
         rd(3'd3 + exp_code, d);
         chk("R9 R7 serviced channel overlay", d, ovl(gsave, ch));
         // a second acknowledge inside the context gets no answer
         ack_strobe = 1'b1; act_chan = ~ch;
         #1;
         chk("R7 no answer in context", {7'd0, vec_oe}, 8'd0);
         @(negedge clk);
         ack_strobe = 1'b0;
         rd(3'd3 + exp_code, d);
         chk("R7 channel unchanged", d, ovl(gsave, ch));
         close_ctx();
         rd(3'd0, d);
         chk("R8 context closed", d, {UID, 3'b000});
      end
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic [7:0] lv [3];
      logic [7:0] gs [3];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      car_val = 3'd0;
      #1;
      for (int s = 0; s < 8; s++) begin
         rd(3'(s), d);
         chk("R1 reset read", d, 8'h00);
      end
      chk("R1 vec_oe reset", {7'd0, vec_oe}, 8'd0);

      wr(3'd0, {UID, 3'b111});
      rd(3'd0, d);
      chk("R2 vector write keeps upper bits", d, {UID, 3'b000});

      lv[0] = 8'h31; lv[1] = 8'h52; lv[2] = 8'h73;
      gs[0] = 8'hA1; gs[1] = 8'h4E; gs[2] = 8'hFF;
      for (int t = 0; t < 3; t++) begin
         wr(3'(1 + t), lv[t]);
         wr(3'(4 + t), gs[t]);
      end
      for (int t = 0; t < 3; t++) begin
         rd(3'(1 + t), d);
         chk("R3 level readback", d, lv[t]);
      end

      // R9 overlay sweep over car_val with no context
      for (int t = 0; t < 3; t++) begin
         for (int c = 0; c < 8; c++) begin
            car_val = 3'(c);
            rd(3'(4 + t), d);
            chk("R9 car overlay", d, ovl(gs[t], 3'(c)));
         end
      end
      car_val = 3'd2;

      // R10 select 7
      wr(3'd7, 8'h5A);
      rd(3'd7, d);
      chk("R10 select 7 zero", d, 8'h00);
      rd(3'd2, d);
      chk("R10 no side write", d, lv[1]);

      // R4 R6 sweep: distinct levels, all pending patterns, each level plus a miss
      for (int p = 0; p < 8; p++) begin
         for (int a = 0; a < 4; a++) begin
            logic [7:0] ad;
            logic [2:0] ec;
            ad = (a < 3) ? lv[a] : 8'hEE;
            ec = (a < 3 && p[a]) ? 3'(a + 1) : 3'd0;
            ack_case(3'(p), ad, ec, 3'(p ^ a), gs[(a < 3) ? a : 0],
                     (ec != 0) ? "R4 match" : "R6 no answer");
         end
      end

      // strobe low: no answer even with matching address
      @(negedge clk);
      pend = 3'b111; ack_addr = lv[2]; ack_strobe = 1'b0;
      #1;
      chk("R6 no strobe", {7'd0, vec_oe}, 8'd0);

      // R5 priority sweep: all levels equal
      for (int t = 0; t < 3; t++) wr(3'(1 + t), 8'hA5);
      for (int p = 0; p < 8; p++) begin
         logic [2:0] ec;
         ec = p[2] ? 3'd3 : p[1] ? 3'd2 : p[0] ? 3'd1 : 3'd0;
         ack_case(3'(p), 8'hA5, ec, 3'(7 - p), gs[(ec != 0) ? ec - 1 : 0], "R5 priority");
      end

      // stored channel bytes untouched by the overlay
      car_val = 3'd0;
      for (int t = 0; t < 3; t++) begin
         rd(3'(4 + t), d);
         chk("R9 storage unchanged", d, ovl(gs[t], 3'd0));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule